// File: doc/BRIEF.md
# Dual-Mode Serial Readout Buffer

This block collects received data bits into a small circular store and hands them to a host one bit at a time. The readout clock can come from either side. In master mode the block produces the clock pulses itself. In slave mode the host toggles the clock pin, and the block advances by one bit on each falling edge it sees. An active-low ready flag tells the host that unread bits are waiting.

A synchronous clear empties the store, clears the sticky overflow flag and disarms the writer. After a clear or a reset, incoming bits are dropped until the first sync-detected pulse arrives. From then on, every valid bit is stored, whether or not sync is still detected. The host may move from master to slave clocking and back in the middle of a readout, and no bit is skipped or read twice. If the host asks for slave mode but does not start its clock within a fixed handover window, the block resumes driving the clock itself.

Top module: `serial_readout_buffer`

## Requirements
- R1: After reset, and one cycle after `buf_clear` is high, `ready_n` is 1, `overflow` is 0 and no bit stored before the clear can ever be read out.
- R2: While the writer is not armed, a `bit_valid` pulse without `sync_hit` stores nothing, so `ready_n` stays 1. Reset and `buf_clear` both disarm the writer.
- R3: A `sync_hit` pulse arms the writer, and a bit that is valid in the same cycle is stored. After that, every `bit_valid` bit is stored whatever `sync_hit` does, until the next clear.
- R4: `ready_n` is 0 exactly when at least one unread bit is stored, and 1 when the store is empty.
- R5: In master mode `rdclk_oe` is 1. For each stored bit, `rdclk_out` is high for `MCLK_HALF` cycles and then low for `MCLK_HALF` cycles. `rd_data` holds that bit from the rise until after the fall, and bits come out in arrival order.
- R6: In slave mode `rdclk_oe` is 0 and `rd_data` shows the oldest unread bit. Each falling edge on `rdclk_in` (with rdclk_in idling high) consumes that bit, and the next bit appears within four clock cycles.
- R7: A change of `mode_slave` from 0 to 1 takes effect only between bits. Master output then stops, and the host continues with the next unread bit, with no bit skipped or repeated.
- R8: If data is waiting and no host falling edge arrives within `HANDOVER_CYCLES` cycles of entering slave mode, the block resumes master output. It stays in master mode until `mode_slave` returns to 0.
- R9: When `mode_slave` returns to 0 in slave mode, master output resumes with the next unread bit.
- R10: A write into a full store drops the oldest bit and sets `overflow`. `overflow` stays 1 until reset or `buf_clear`.
- R11: A host falling edge while the store is empty consumes nothing. A bit written later is read out intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| buf_clear | input | 1 | Synchronous clear of store, overflow and arming |
| bit_in | input | 1 | Received data bit |
| bit_valid | input | 1 | Strobe qualifying bit_in |
| sync_hit | input | 1 | Sync-detected pulse that arms the writer |
| mode_slave | input | 1 | 1 asks for host-clocked readout, 0 for block-clocked |
| rdclk_in | input | 1 | Readout clock from the host (idles high) |
| rdclk_out | output | 1 | Readout clock driven by the block |
| rdclk_oe | output | 1 | Enable for the block's readout clock driver |
| rd_data | output | 1 | Oldest unread bit |
| ready_n | output | 1 | 0 while unread bits are stored |
| overflow | output | 1 | Sticky flag for a bit lost to a full store |

## Verification
The properties assume that `mode_slave`, `bit_valid`, `sync_hit` and `buf_clear` are synchronous to `clk`. They also assume that `rdclk_in` stays high except for host clock pulses, each of which is held low and then high long enough for the two-flop synchronizer. The stimulus drives all synchronous inputs between clock edges. It holds every host clock level for four cycles and waits for `rdclk_oe` to drop before it starts host reads. In master mode it paces writes so that the store never fills, so overflow occurs only in slave mode, where nothing drains.

// File: rtl/srb_pkg.sv
package srb_pkg;
    typedef enum logic [2:0] {
        RD_IDLE,
        RD_HIGH,
        RD_LOW,
        RD_WAIT,
        RD_HOST
    } rd_state_e;
endpackage

// File: rtl/srb_edge_sync.sv
module srb_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);
    typedef struct packed {
        logic [2:0] sh;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.sh = {s_q.sh[1:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{sh: 3'b111};
        else        s_q <= s_d;
    end

    // sh[1] is the synchronized level, sh[2] its previous value
    assign fall_o = s_q.sh[2] & ~s_q.sh[1];
endmodule

// File: rtl/srb_store.sv
module srb_store #(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic sync_hit_i,
    input  logic bit_i,
    input  logic valid_i,
    input  logic pop_i,
    output logic head_o,
    output logic empty_o,
    output logic full_o,
    output logic overflow_o,
    output logic armed_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0] mem;
        logic [AW-1:0]    wr;
        logic [AW-1:0]    rd;
        logic [CW-1:0]    cnt;
        logic             armed;
        logic             ovf;
    } store_t;

    localparam store_t STORE_RST = '{mem: '0, wr: '0, rd: '0, cnt: '0, armed: 1'b0, ovf: 1'b0};

    store_t s_d, s_q;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    logic wr_en, do_pop, is_full;

    always_comb begin
        s_d     = s_q;
        is_full = (s_q.cnt == FULL_CNT);
        wr_en   = valid_i && (s_q.armed || sync_hit_i);
        do_pop  = pop_i && (s_q.cnt != '0);

        if (sync_hit_i) s_d.armed = 1'b1;

        if (do_pop) s_d.rd = step(s_q.rd);

        if (wr_en) begin
            s_d.mem[s_q.wr] = bit_i;
            s_d.wr          = step(s_q.wr);
            if (is_full && !do_pop) begin
                s_d.rd  = step(s_q.rd);
                s_d.ovf = 1'b1;
            end else if (!do_pop) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (do_pop) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end

        if (clear_i) s_d = STORE_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= STORE_RST;
        else        s_q <= s_d;
    end

    assign head_o     = s_q.mem[s_q.rd];
    assign empty_o    = (s_q.cnt == '0);
    assign full_o     = (s_q.cnt == FULL_CNT);
    assign overflow_o = s_q.ovf;
    assign armed_o    = s_q.armed;
endmodule

// File: rtl/srb_readout_ctrl.sv
module srb_readout_ctrl
    import srb_pkg::*;
#(
    parameter int MCLK_HALF       = 4,
    parameter int HANDOVER_CYCLES = 42000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic mode_slave_i,
    input  logic host_fall_i,
    input  logic empty_i,
    output logic pop_o,
    output logic clk_out_o,
    output logic clk_oe_o
);
    localparam int PW = (MCLK_HALF > 1) ? $clog2(MCLK_HALF) : 1;
    localparam int TW = $clog2(HANDOVER_CYCLES + 1);
    localparam logic [PW-1:0] PH_LAST = PW'(MCLK_HALF - 1);
    localparam logic [TW-1:0] T_LAST  = TW'(HANDOVER_CYCLES - 1);

    typedef struct packed {
        rd_state_e     st;
        logic [PW-1:0] ph;
        logic [TW-1:0] tmr;
        logic          forced;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{st: RD_IDLE, ph: '0, tmr: '0, forced: 1'b0};

    ctrl_t c_d, c_q;
    logic  pop_c;

    always_comb begin
        c_d   = c_q;
        pop_c = 1'b0;

        if (!mode_slave_i) c_d.forced = 1'b0;

        unique case (c_q.st)
            RD_IDLE: begin
                if (mode_slave_i && !c_q.forced) begin
                    c_d.st  = RD_WAIT;
                    c_d.tmr = '0;
                end else if (!empty_i) begin
                    c_d.st = RD_HIGH;
                    c_d.ph = '0;
                end
            end
            RD_HIGH: begin
                if (c_q.ph == PH_LAST) begin
                    c_d.st = RD_LOW;
                    c_d.ph = '0;
                end else begin
                    c_d.ph = c_q.ph + 1'b1;
                end
            end
            RD_LOW: begin
                if (c_q.ph == PH_LAST) begin
                    pop_c  = 1'b1;
                    c_d.st = RD_IDLE;
                    c_d.ph = '0;
                end else begin
                    c_d.ph = c_q.ph + 1'b1;
                end
            end
            RD_WAIT: begin
                if (!mode_slave_i) begin
                    c_d.st = RD_IDLE;
                end else if (host_fall_i) begin
                    pop_c  = 1'b1;
                    c_d.st = RD_HOST;
                end else if ((c_q.tmr >= T_LAST) && !empty_i) begin
                    c_d.forced = 1'b1;
                    c_d.st     = RD_IDLE;
                end else if (c_q.tmr < T_LAST) begin
                    c_d.tmr = c_q.tmr + 1'b1;
                end
            end
            RD_HOST: begin
                if (!mode_slave_i)     c_d.st = RD_IDLE;
                else if (host_fall_i)  pop_c  = 1'b1;
            end
            default: c_d.st = RD_IDLE;
        endcase

        if (clear_i) begin
            pop_c = 1'b0;
            if (c_q.st == RD_HIGH || c_q.st == RD_LOW) begin
                c_d.st = RD_IDLE;
                c_d.ph = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= CTRL_RST;
        else        c_q <= c_d;
    end

    assign pop_o     = pop_c;
    assign clk_out_o = (c_q.st == RD_HIGH);
    assign clk_oe_o  = (c_q.st == RD_IDLE) || (c_q.st == RD_HIGH) || (c_q.st == RD_LOW);
endmodule

// File: rtl/serial_readout_buffer.sv
module serial_readout_buffer #(
    parameter int DEPTH           = 16,
    parameter int MCLK_HALF       = 4,
    parameter int HANDOVER_CYCLES = 42000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic buf_clear,
    input  logic bit_in,
    input  logic bit_valid,
    input  logic sync_hit,
    input  logic mode_slave,
    input  logic rdclk_in,
    output logic rdclk_out,
    output logic rdclk_oe,
    output logic rd_data,
    output logic ready_n,
    output logic overflow
);
    logic host_fall_w, pop_w, empty_w, full_w, armed_w;

    srb_edge_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (rdclk_in),
        .fall_o (host_fall_w)
    );

    srb_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (buf_clear),
        .sync_hit_i (sync_hit),
        .bit_i      (bit_in),
        .valid_i    (bit_valid),
        .pop_i      (pop_w),
        .head_o     (rd_data),
        .empty_o    (empty_w),
        .full_o     (full_w),
        .overflow_o (overflow),
        .armed_o    (armed_w)
    );

    srb_readout_ctrl #(
        .MCLK_HALF       (MCLK_HALF),
        .HANDOVER_CYCLES (HANDOVER_CYCLES)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (buf_clear),
        .mode_slave_i (mode_slave),
        .host_fall_i  (host_fall_w),
        .empty_i      (empty_w),
        .pop_o        (pop_w),
        .clk_out_o    (rdclk_out),
        .clk_oe_o     (rdclk_oe)
    );

    assign ready_n = empty_w;
endmodule

// File: rtl/srb_checker.sv
module srb_checker (
    input logic clk,
    input logic rst_n,
    input logic buf_clear,
    input logic bit_valid,
    input logic sync_hit,
    input logic rdclk_out,
    input logic rd_data,
    input logic ready_n,
    input logic overflow,
    input logic armed,
    input logic full
);
    p_clear_empties_r1: assert property (@(posedge clk) disable iff (!rst_n)
        buf_clear |=> (ready_n && !overflow));

    p_gated_before_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !sync_hit && ready_n && !buf_clear) |=> ready_n);

    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && (armed || sync_hit) && !buf_clear) |=> !ready_n);

    p_head_holds_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rdclk_out && !buf_clear && !full) |=> $stable(rd_data));

    p_overflow_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !buf_clear) |=> overflow);

    p_overflow_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(full && bit_valid));
endmodule

bind serial_readout_buffer srb_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .buf_clear (buf_clear),
    .bit_valid (bit_valid),
    .sync_hit  (sync_hit),
    .rdclk_out (rdclk_out),
    .rd_data   (rd_data),
    .ready_n   (ready_n),
    .overflow  (overflow),
    .armed     (armed_w),
    .full      (full_w)
);

// File: tb/test_serial_readout_buffer.sv
module test_serial_readout_buffer;
    localparam int DEPTH = 8;
    localparam int HALF  = 2;
    localparam int HOVER = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic buf_clear = 1'b0, bit_in = 1'b0, bit_valid = 1'b0, sync_hit = 1'b0;
    logic mode_slave = 1'b0, rdclk_in = 1'b1;
    logic rdclk_out, rdclk_oe, rd_data, ready_n, overflow;

    int checks = 0;
    int fails  = 0;
    int mfalls = 0;
    bit model_armed = 1'b0;
    bit q[$];
    logic prev_out = 1'b0;

    always #10 clk = ~clk;

    serial_readout_buffer #(.DEPTH(DEPTH), .MCLK_HALF(HALF), .HANDOVER_CYCLES(HOVER)) i_serial_readout_buffer (
        .clk(clk), .rst_n(rst_n), .buf_clear(buf_clear), .bit_in(bit_in),
        .bit_valid(bit_valid), .sync_hit(sync_hit), .mode_slave(mode_slave),
        .rdclk_in(rdclk_in), .rdclk_out(rdclk_out), .rdclk_oe(rdclk_oe),
        .rd_data(rd_data), .ready_n(ready_n), .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // driver: one bit per two cycles, model pushes what should be stored
    task automatic put(input bit b, input bit s);
        @(negedge clk);
        bit_in = b; bit_valid = 1'b1; sync_hit = s;
        if (s) model_armed = 1'b1;
        if (model_armed) begin
            q.push_back(b);
            if (q.size() > DEPTH) void'(q.pop_front());
        end
        @(negedge clk);
        bit_valid = 1'b0; sync_hit = 1'b0;
    endtask

    // host read in slave mode: sample head, then one falling edge (R6)
    task automatic host_read(input string req);
        bit e;
        @(negedge clk);
        if (q.size() == 0) begin
            check(1'b0, req, rd_data, -1);
        end else begin
            e = q.pop_front();
            check(rd_data == e, req, rd_data, e);
        end
        rdclk_in = 1'b0;
        repeat (4) @(negedge clk);
        rdclk_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // monitor: bits taken on master falling edges (R5)
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_out && !rdclk_out && rdclk_oe) begin
                mfalls++;
                if (q.size() == 0) begin
                    check(1'b0, "R5 unexpected master bit", rd_data, -1);
                end else begin
                    automatic bit e = q.pop_front();
                    check(rd_data == e, "R5 master bit order", rd_data, e);
                end
            end
            prev_out = rdclk_out;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ready_n == 1'b1, "R1 ready_n after reset", ready_n, 1);
        check(overflow == 1'b0, "R1 overflow after reset", overflow, 0);
        check(rdclk_oe == 1'b1 && rdclk_out == 1'b0, "R5 master idle", rdclk_out, 0);

        // R2 writes before sync are dropped
        put(1'b1, 1'b0); put(1'b0, 1'b0); put(1'b1, 1'b0);
        repeat (6) @(negedge clk);
        check(ready_n == 1'b1, "R2 unarmed writes dropped", ready_n, 1);
        check(mfalls == 0, "R2 nothing clocked out", mfalls, 0);

        // R3 arm with sync and store in the same cycle, later bits without sync
        put(1'b1, 1'b1);
        put(1'b0, 1'b0); put(1'b1, 1'b0); put(1'b1, 1'b0); put(1'b0, 1'b0); put(1'b1, 1'b0);
        repeat (40) @(negedge clk);
        check(mfalls == 6, "R3 all six bits clocked out", mfalls, 6);
        check(q.size() == 0 && ready_n, "R4 empty after master drain", q.size(), 0);

        // slave mode, R11 falling edge on an empty store
        mode_slave = 1'b1;
        repeat (3) @(negedge clk);
        check(rdclk_oe == 1'b0, "R6 slave releases clock", rdclk_oe, 0);
        rdclk_in = 1'b0; repeat (4) @(negedge clk);
        rdclk_in = 1'b1; repeat (4) @(negedge clk);
        put(1'b0, 1'b0); put(1'b1, 1'b0); put(1'b1, 1'b0); put(1'b0, 1'b0);
        check(ready_n == 1'b0, "R4 ready_n low with data", ready_n, 0);
        check(rd_data == 1'b0, "R11 first bit after empty edge intact", rd_data, 0);
        repeat (4) host_read("R6 slave readout");
        check(ready_n == 1'b1, "R4 ready_n high when drained", ready_n, 1);

        // R10 overflow in slave mode
        for (int i = 0; i < DEPTH + 2; i++) put(1'((i * 5 + 1) % 3 == 0), 1'b0);
        check(overflow == 1'b1, "R10 overflow set", overflow, 1);
        for (int i = 0; i < DEPTH; i++) host_read("R10 newest bits kept");
        check(ready_n == 1'b1, "R10 depth bits only", ready_n, 1);
        check(overflow == 1'b1, "R10 overflow sticky", overflow, 1);

        // R1 clear, then R2 again
        put(1'b1, 1'b0); put(1'b1, 1'b0);
        @(negedge clk); buf_clear = 1'b1;
        @(negedge clk); buf_clear = 1'b0;
        q.delete(); model_armed = 1'b0;
        check(ready_n == 1'b1, "R1 clear empties", ready_n, 1);
        check(overflow == 1'b0, "R1 clear drops overflow", overflow, 0);
        check(rd_data == 1'b0, "R1 no stale data", rd_data, 0);
        put(1'b1, 1'b0); put(1'b1, 1'b0);
        check(ready_n == 1'b1, "R2 disarmed after clear", ready_n, 1);

        // R9 slave back to master mid readout
        put(1'b1, 1'b1); put(1'b0, 1'b0); put(1'b1, 1'b0);
        host_read("R9 slave part");
        mode_slave = 1'b0;
        repeat (40) @(negedge clk);
        check(q.size() == 0 && ready_n, "R9 master finished the rest", q.size(), 0);

        // R7 master to slave mid readout
        base = mfalls;
        put(1'b1, 1'b0); put(1'b0, 1'b0); put(1'b0, 1'b0);
        put(1'b1, 1'b0); put(1'b1, 1'b0); put(1'b0, 1'b0);
        wait (mfalls >= base + 2);
        @(negedge clk); mode_slave = 1'b1;
        wait (!rdclk_oe);
        while (!ready_n) host_read("R7 handover continues");
        check(q.size() == 0, "R7 no bit skipped or repeated", q.size(), 0);

        // R8 handover window expires
        mode_slave = 1'b0;
        repeat (3) @(negedge clk);
        mode_slave = 1'b1;
        repeat (2) @(negedge clk);
        put(1'b1, 1'b0); put(1'b0, 1'b0);
        repeat (10) @(negedge clk);
        check(rdclk_oe == 1'b0 && ready_n == 1'b0, "R8 waiting inside window", rdclk_oe, 0);
        repeat (60) @(negedge clk);
        check(rdclk_oe == 1'b1, "R8 master resumed", rdclk_oe, 1);
        check(q.size() == 0 && ready_n, "R8 data drained by block", q.size(), 0);
        put(1'b1, 1'b0);
        repeat (20) @(negedge clk);
        check(q.size() == 0 && rdclk_oe, "R8 stays master while mode high", q.size(), 0);
        mode_slave = 1'b0;
        repeat (5) @(negedge clk);

        summary();
        $finish;
    end
endmodule